// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter Pair

This block holds two timer/counter channels. Each channel has a low count byte and a high count byte. Its own 2-bit mode field arranges those bytes as a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself, or a split layout. A channel advances on a machine-cycle tick, or on falling edges of its external count pin. Counting runs only while the run bit allows it, and optionally only while an external gate pin is high, so that a pulse width can be measured. Software can load any count byte through a small write port. Each channel has a sticky overflow flag. Software clears it with a write strobe, or the interrupt logic clears it with an acknowledge pulse.

The split mode is set on channel 0. In that mode its low byte becomes an 8-bit counter that keeps all of channel 0's controls. Its high byte becomes a second 8-bit timer that counts ticks only, runs on channel 1's run bit and reports through channel 1's flag. Channel 1 keeps counting in its own modes and drives a one-cycle overflow strobe for a baud-rate divider, but it no longer touches its flag. Putting channel 1 itself into the split code freezes it.

Top module: `dual_timer_pair`

## Requirements
- R1: When extSel[i]=0, channel i counts one step per cycle with tick=1. When extSel[i]=1, it counts one step for each 1-to-0 transition of cntPin[i]. The pin passes through two synchronising flip-flops, and a transition seen while tick=0 is held until the next cycle with tick=1, so with tick held at 1 the count changes on the third rising clock edge after the pin falls. Rising pin edges never count.
- R2: Channel i counts only while runBit[i]=1 and either gateEn[i]=0 or gatePin[i]=1.
- R3: Mode code 0 forms a 13-bit counter, {high byte, low byte bits 4:0}. Low byte bits 7:5 keep their written value. The flag is set when all 13 bits wrap from ones to zeros.
- R4: Mode code 1 forms a 16-bit counter, {high, low}. The flag is set when it wraps from 0xFFFF to 0x0000.
- R5: Mode code 2 counts the low byte only. A step taken at 0xFF loads the low byte from the high byte and sets the flag. The high byte is unchanged.
- R6: A channel with runBit=0 holds its count. Setting runBit again resumes counting from the held value, without clearing it.
- R7: Channel 1 with mode code 3 holds its count. Moving it back to codes 0 to 2 lets it count again.
- R8: With channel 0 at mode code 3, its low byte is an 8-bit counter using channel 0's controls, and its wrap sets flag[0]. Its high byte counts tick cycles while runBit[1]=1, and its wrap sets flag[1].
- R9: With channel 0 at mode code 3, channel 1 still counts in codes 0 to 2, but its overflow no longer sets flag[1].
- R10: baudStrobe is high for exactly the cycle after each channel-1 overflow, in every mode except code 3.
- R11: flag[i] is sticky. flagClr[i] or intAck[i] clears it, and an overflow in the same cycle as a clear leaves it set.
- R12: wrAddr selects a byte: bit 1 is the channel, and bit 0 picks the high byte (1) or the low byte (0). A write loads wrData and cancels the count step of the counter holding that byte in the same cycle.
- R13: After reset both counts, both flags and baudStrobe are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle tick |
| cntPin | input | 2 | External count pins, one per channel |
| gatePin | input | 2 | External gate pins, one per channel |
| runBit | input | 2 | Run bits, one per channel |
| extSel | input | 2 | Count source: 0 tick, 1 external pin |
| gateEn | input | 2 | Gate pin qualifies counting when 1 |
| modeSel0 | input | 2 | Channel 0 mode code |
| modeSel1 | input | 2 | Channel 1 mode code |
| wrEn | input | 1 | Count byte write strobe |
| wrAddr | input | 2 | Byte select: bit 1 channel, bit 0 high byte |
| wrData | input | 8 | Write data |
| flagClr | input | 2 | Software flag clear |
| intAck | input | 2 | Interrupt acknowledge flag clear |
| flag | output | 2 | Sticky overflow flags |
| baudStrobe | output | 1 | One-cycle channel 1 overflow pulse |
| count0 | output | 16 | Channel 0 {high, low} |
| count1 | output | 16 | Channel 1 {high, low} |

## Verification
On every cycle, the assertions check that a flag stays set until it is cleared, that a frozen channel 1 does not move, that a stopped or gated-off channel 0 holds its count, that a written byte shows the written value, and that baudStrobe never follows a cycle in which channel 1 was frozen. Only the bench's scenarios can show the arithmetic of each counting geometry, the reload value, the flag routing in split mode, the synchroniser latency of the pin path with its pending event, and the tie between a clear and a new overflow.

// File: rtl/dual_timer_pair_pkg.sv
package dual_timer_pair_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmrMode_e;

  typedef struct packed {
    logic [NCH-1:0] inc;     // per-channel main count step
    logic           incHi0;  // channel 0 high byte step in split mode
  } tmrStrobe_t;
endpackage

// File: rtl/dual_timer_pair_ctrl.sv
module dual_timer_pair_ctrl
  import dual_timer_pair_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [NCH-1:0]   cntPin,
  input  logic [NCH-1:0]   gatePin,
  input  logic [NCH-1:0]   runBit,
  input  logic [NCH-1:0]   extSel,
  input  logic [NCH-1:0]   gateEn,
  input  tmrMode_e         mode0,
  input  tmrMode_e         mode1,
  input  logic [NCH-1:0]   ovfMain,
  input  logic             ovfHi0,
  input  logic [NCH-1:0]   flagClr,
  input  logic [NCH-1:0]   intAck,
  output tmrStrobe_t       strobe,
  output logic [NCH-1:0]   flag,
  output logic             baudStrobe
);
  logic [NCH-1:0] syncA, syncB, syncPrev, pend;
  logic [NCH-1:0] fall, evt, src, gateOk, live, flagSet;
  logic           split0, split1;

  assign split0 = (mode0 == MODE_SPLIT);
  assign split1 = (mode1 == MODE_SPLIT);

  // two-stage synchroniser plus edge history, pins idle high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= '1;
      syncB    <= '1;
      syncPrev <= '1;
      pend     <= '0;
    end else begin
      syncA    <= cntPin;
      syncB    <= syncA;
      syncPrev <= syncB;
      pend     <= (pend | fall) & ~{NCH{tick}};
    end
  end

  assign fall   = syncPrev & ~syncB;
  assign evt    = {NCH{tick}} & (pend | fall);
  assign src    = (extSel & evt) | (~extSel & {NCH{tick}});
  assign gateOk = ~gateEn | gatePin;
  assign live   = runBit & gateOk & src;

  assign strobe.inc    = live & {~split1, 1'b1};
  assign strobe.incHi0 = split0 & tick & runBit[1];

  assign flagSet[0] = ovfMain[0];
  assign flagSet[1] = split0 ? ovfHi0 : ovfMain[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag       <= '0;
      baudStrobe <= 1'b0;
    end else begin
      flag       <= flagSet | (flag & ~(flagClr | intAck));
      baudStrobe <= ovfMain[1];
    end
  end
endmodule

// File: rtl/dual_timer_pair_dp.sv
module dual_timer_pair_dp
  import dual_timer_pair_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  tmrMode_e          mode0,
  input  tmrMode_e          mode1,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [2*BYTE_W-1:0] count0,
  output logic [2*BYTE_W-1:0] count1,
  output logic [NCH-1:0]    ovfMain,
  output logic              ovfHi0
);
  localparam int CW = 2 * BYTE_W;

  logic [NCH-1:0][CW-1:0] cnt;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tmrMode_e          m;
    logic [BYTE_W-1:0] lo, hi, loNext, hiNext;
    logic              selCh, wrLo, wrHi, split, stepMain, hiBump, ovf;

    assign m        = (ch == 0) ? mode0 : mode1;
    assign split    = (m == MODE_SPLIT);
    assign selCh    = wrEn && (wrAddr[1] == (ch == 1));
    assign wrLo     = selCh && !wrAddr[0];
    assign wrHi     = selCh && wrAddr[0];
    assign stepMain = strobe.inc[ch] && !(split ? wrLo : (wrLo || wrHi));
    assign hiBump   = (ch == 0) ? (strobe.incHi0 && !wrHi) : 1'b0;

    always_comb begin
      loNext = lo;
      hiNext = hi;
      ovf    = 1'b0;
      if (stepMain) begin
        case (m)
          MODE_13: begin
            loNext[PRE_W-1:0] = lo[PRE_W-1:0] + PRE_W'(1);
            if (&lo[PRE_W-1:0]) begin
              hiNext = hi + BYTE_W'(1);
              ovf    = &hi;
            end
          end
          MODE_16: begin
            {hiNext, loNext} = {hi, lo} + CW'(1);
            ovf              = &{hi, lo};
          end
          MODE_RELOAD: begin
            if (&lo) begin
              loNext = hi;
              ovf    = 1'b1;
            end else begin
              loNext = lo + BYTE_W'(1);
            end
          end
          default: begin
            loNext = lo + BYTE_W'(1);
            ovf    = &lo;
          end
        endcase
      end
      if (hiBump) hiNext = hi + BYTE_W'(1);
      if (wrLo)   loNext = wrData;
      if (wrHi)   hiNext = wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lo <= '0;
        hi <= '0;
      end else begin
        lo <= loNext;
        hi <= hiNext;
      end
    end

    assign cnt[ch]     = {hi, lo};
    assign ovfMain[ch] = ovf;
  end

  assign ovfHi0 = strobe.incHi0 && !(wrEn && wrAddr == 2'b01) && (&cnt[0][CW-1:BYTE_W]);
  assign count0 = cnt[0];
  assign count1 = cnt[1];
endmodule

// File: rtl/dual_timer_pair.sv
module dual_timer_pair
  import dual_timer_pair_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic [1:0]          cntPin,
  input  logic [1:0]          gatePin,
  input  logic [1:0]          runBit,
  input  logic [1:0]          extSel,
  input  logic [1:0]          gateEn,
  input  logic [1:0]          modeSel0,
  input  logic [1:0]          modeSel1,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [1:0]          flagClr,
  input  logic [1:0]          intAck,
  output logic [1:0]          flag,
  output logic                baudStrobe,
  output logic [2*BYTE_W-1:0] count0,
  output logic [2*BYTE_W-1:0] count1
);
  tmrStrobe_t     strobe;
  logic [NCH-1:0] ovfMain;
  logic           ovfHi0;
  tmrMode_e       mode0, mode1;

  assign mode0 = tmrMode_e'(modeSel0);
  assign mode1 = tmrMode_e'(modeSel1);

  dual_timer_pair_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .cntPin(cntPin), .gatePin(gatePin),
    .runBit(runBit), .extSel(extSel), .gateEn(gateEn), .mode0(mode0), .mode1(mode1),
    .ovfMain(ovfMain), .ovfHi0(ovfHi0), .flagClr(flagClr), .intAck(intAck),
    .strobe(strobe), .flag(flag), .baudStrobe(baudStrobe)
  );

  dual_timer_pair_dp #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode0(mode0), .mode1(mode1),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .count0(count0), .count1(count1),
    .ovfMain(ovfMain), .ovfHi0(ovfHi0)
  );
endmodule

// File: rtl/dual_timer_pair_chk.sv
module dual_timer_pair_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          gatePin,
  input logic [1:0]          runBit,
  input logic [1:0]          gateEn,
  input logic [1:0]          modeSel0,
  input logic [1:0]          modeSel1,
  input logic                wrEn,
  input logic [1:0]          wrAddr,
  input logic [BYTE_W-1:0]   wrData,
  input logic [1:0]          flagClr,
  input logic [1:0]          intAck,
  input logic [1:0]          flag,
  input logic                baudStrobe,
  input logic [2*BYTE_W-1:0] count0,
  input logic [2*BYTE_W-1:0] count1
);
  logic wrCh0, wrCh1;
  assign wrCh0 = wrEn && !wrAddr[1];
  assign wrCh1 = wrEn && wrAddr[1];

  assert_flag_sticky0_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flag[0] && !flagClr[0] && !intAck[0]) |=> flag[0]);

  assert_flag_sticky1_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flag[1] && !flagClr[1] && !intAck[1]) |=> flag[1]);

  assert_frozen_ch1_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel1 == 2'd3 && !wrCh1) |=> $stable(count1));

  assert_stopped_ch0_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit[0] && modeSel0 != 2'd3 && !wrCh0) |=> $stable(count0));

  assert_gated_ch0_R2: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn[0] && !gatePin[0] && modeSel0 != 2'd3 && !wrCh0) |=> $stable(count0));

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'b00) |=> (count0[BYTE_W-1:0] == $past(wrData)));

  assert_no_baud_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    baudStrobe |-> ($past(modeSel1) != 2'd3));
endmodule

bind dual_timer_pair dual_timer_pair_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .gatePin(gatePin), .runBit(runBit), .gateEn(gateEn),
  .modeSel0(modeSel0), .modeSel1(modeSel1), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .flagClr(flagClr), .intAck(intAck), .flag(flag),
  .baudStrobe(baudStrobe), .count0(count0), .count1(count1)
);

// File: tb/dual_timer_pair_tb.sv
module dual_timer_pair_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  cntPin = 2'b11, gatePin = 2'b00, runBit = 2'b00, extSel = 2'b00, gateEn = 2'b00;
  logic [1:0]  modeSel0 = 2'd1, modeSel1 = 2'd1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'b00;
  logic [7:0]  wrData = 8'h00;
  logic [1:0]  flagClr = 2'b00, intAck = 2'b00;
  logic [1:0]  flag;
  logic        baudStrobe;
  logic [15:0] count0, count1;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  typedef struct {
    string req;
    int    sel;
    int    exp;
  } item_t;
  item_t expQ[$];
  event  chkEv;

  always #2 clk = ~clk;

  dual_timer_pair u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .cntPin(cntPin), .gatePin(gatePin),
    .runBit(runBit), .extSel(extSel), .gateEn(gateEn), .modeSel0(modeSel0),
    .modeSel1(modeSel1), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .flagClr(flagClr), .intAck(intAck), .flag(flag), .baudStrobe(baudStrobe),
    .count0(count0), .count1(count1)
  );

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(chkEv);
      while (expQ.size() > 0) begin
        item_t it;
        int act;
        it = expQ.pop_front();
        case (it.sel)
          0:       act = int'(count0);
          1:       act = int'(count1);
          2:       act = int'(flag);
          default: act = int'(baudStrobe);
        endcase
        testsRun++;
        if (act != it.exp) begin
          testsFailed++;
          $display("FAIL %s: actual %0h expected %0h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic expectV(string req, int sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    expQ.push_back(it);
    -> chkEv;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic stepTicks(int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulseClr(logic [1:0] c, logic [1:0] a);
    @(negedge clk); flagClr = c; intAck = a;
    @(negedge clk); flagClr = 2'b00; intAck = 2'b00;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R13 reset state
    expectV("R13 count0", 0, 0);
    expectV("R13 count1", 1, 0);
    expectV("R13 flag", 2, 0);
    expectV("R13 baud", 3, 0);

    // R4 16-bit wrap
    doWrite(2'b00, 8'hFE); doWrite(2'b01, 8'hFF);
    @(negedge clk); runBit = 2'b01;
    stepTicks(1);
    expectV("R4 count", 0, 'hFFFF);
    expectV("R4 no flag yet", 2, 0);
    stepTicks(1);
    expectV("R4 wrap", 0, 0);
    expectV("R4 flag", 2, 1);

    // R11 software clear
    pulseClr(2'b01, 2'b00);
    expectV("R11 clr", 2, 0);

    // R3 13-bit geometry
    @(negedge clk); modeSel0 = 2'd0;
    doWrite(2'b00, 8'hFF); doWrite(2'b01, 8'h00);
    stepTicks(1);
    expectV("R3 carry", 0, 'h01E0);
    doWrite(2'b01, 8'hFF); doWrite(2'b00, 8'h1F);
    stepTicks(1);
    expectV("R3 wrap", 0, 0);
    expectV("R3 flag", 2, 1);
    pulseClr(2'b00, 2'b01);
    expectV("R11 ack", 2, 0);

    // R12 write beats a concurrent tick
    @(negedge clk); modeSel0 = 2'd1;
    @(negedge clk); tick = 1'b1; wrEn = 1'b1; wrAddr = 2'b00; wrData = 8'h55;
    @(negedge clk); tick = 1'b0; wrEn = 1'b0;
    expectV("R12 priority", 0, 'h0055);
    stepTicks(1);
    expectV("R12 then count", 0, 'h0056);

    // R6 run bit hold and resume
    @(negedge clk); runBit = 2'b00;
    stepTicks(3);
    expectV("R6 hold", 0, 'h0056);
    @(negedge clk); runBit = 2'b01;
    waitCyc(1);
    expectV("R6 no clear", 0, 'h0056);
    stepTicks(1);
    expectV("R6 resume", 0, 'h0057);

    // R2 gate
    @(negedge clk); gateEn = 2'b01; gatePin = 2'b00;
    stepTicks(2);
    expectV("R2 gated", 0, 'h0057);
    @(negedge clk); gatePin = 2'b01;
    stepTicks(2);
    expectV("R2 open", 0, 'h0059);
    @(negedge clk); gateEn = 2'b00;

    // R11 set wins over clear
    doWrite(2'b00, 8'hFF); doWrite(2'b01, 8'hFF);
    @(negedge clk); tick = 1'b1; flagClr = 2'b01;
    @(negedge clk); tick = 1'b0; flagClr = 2'b00;
    expectV("R11 set wins", 2, 1);
    expectV("R4 wrap again", 0, 0);
    pulseClr(2'b01, 2'b00);

    // R1 external events
    @(negedge clk); extSel = 2'b01; tick = 1'b1;
    cntPin[0] = 1'b0; waitCyc(5);
    expectV("R1 fall", 0, 1);
    cntPin[0] = 1'b1; waitCyc(5);
    expectV("R1 rise ignored", 0, 1);
    cntPin[0] = 1'b0; waitCyc(5);
    expectV("R1 second fall", 0, 2);
    cntPin[0] = 1'b1; waitCyc(5);
    tick = 1'b0;
    cntPin[0] = 1'b0; waitCyc(5);
    expectV("R1 waits tick", 0, 2);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    expectV("R1 pending", 0, 3);
    extSel = 2'b00; cntPin = 2'b11;

    // R5 reload on channel 1, R10 strobe
    @(negedge clk); modeSel1 = 2'd2; runBit = 2'b10;
    doWrite(2'b11, 8'hF0); doWrite(2'b10, 8'hFE);
    stepTicks(1);
    expectV("R5 step", 1, 'hF0FF);
    expectV("R10 quiet", 3, 0);
    stepTicks(1);
    expectV("R5 reload", 1, 'hF0F0);
    expectV("R5 flag", 2, 2);
    expectV("R10 pulse", 3, 1);
    waitCyc(1);
    expectV("R10 one cycle", 3, 0);
    pulseClr(2'b00, 2'b10);
    expectV("R11 ack1", 2, 0);

    // R8 split mode
    @(negedge clk); modeSel0 = 2'd3; modeSel1 = 2'd1; runBit = 2'b11;
    doWrite(2'b00, 8'hFE); doWrite(2'b01, 8'hFF);
    doWrite(2'b10, 8'h00); doWrite(2'b11, 8'h00);
    stepTicks(1);
    expectV("R8 hi wrap", 0, 'h00FF);
    expectV("R8 flag1", 2, 2);
    expectV("R9 ch1 runs", 1, 1);
    stepTicks(1);
    expectV("R8 lo wrap", 0, 'h0100);
    expectV("R8 flag0", 2, 3);
    pulseClr(2'b11, 2'b00);

    // R9 channel 1 overflow: strobe only
    @(negedge clk); runBit = 2'b10;
    doWrite(2'b10, 8'hFF); doWrite(2'b11, 8'hFF); doWrite(2'b01, 8'h00);
    stepTicks(1);
    expectV("R9 ch1 wrap", 1, 0);
    expectV("R9 baud", 3, 1);
    expectV("R9 no flag1", 2, 0);
    expectV("R8 hi only", 0, 'h0100);

    // R7 freeze channel 1
    @(negedge clk); modeSel1 = 2'd3;
    stepTicks(3);
    expectV("R7 frozen", 1, 0);
    expectV("R8 hi keeps", 0, 'h0400);
    @(negedge clk); modeSel1 = 2'd1;
    stepTicks(1);
    expectV("R7 restart", 1, 1);

    waitCyc(2);
    finished = 1;
    summary();
  end
endmodule